// File: doc/BRIEF.md
# Keyboard Wake and Status Deglitch Controller

This block turns the columns of a keyboard scan port into two requests for a low-power system: an interrupt request for the processor and a wake-up request for the power manager. Two configuration bits shape the result. The first, a direct-wake enable, lets a keypress wake the system even when the keyboard interrupt is masked. The second, a six-column mode, limits the merge to the lowest six columns so that the top two port pins can serve as general-purpose I/O. An external wake pin also raises the wake-up request.

A second function cleans up a slow external status line, such as a media-change detector. That line is sampled by a low-frequency clock of about 16 kHz and must be seen high on two consecutive samples before it is reported. The reported flag drops as soon as one sample is low.

The keyboard columns and the wake pin are synchronized into the system clock before they are used. The configuration and mask bits are captured in registers that clear on reset. Reset is synchronous and active low. It must be held across at least two edges of the slow clock.

Top module: `kbd_wake_ctrl`

## Requirements
- R1: While rst_n is low, kbd_irq_o, wake_req_o and status_flag_o are all driven low at the next clock edge of their domain. After release with idle inputs they stay low.
- R2: When cfg_six_col_i is 0, a high level on any of the eight bits of kbd_col_i counts as a keypress.
- R3: When cfg_six_col_i is 1, bits 7 and 6 of kbd_col_i have no effect on kbd_irq_o or wake_req_o. Bits 5 down to 0 still count as keypresses.
- R4: When cfg_direct_wake_i is 1, a keypress drives wake_req_o high whatever the value of kbd_mask_i.
- R5: When cfg_direct_wake_i and kbd_mask_i are both 0, a keypress leaves wake_req_o low.
- R6: kbd_irq_o is high only for a keypress with kbd_mask_i set, whatever the value of cfg_direct_wake_i.
- R7: A change on kbd_col_i reaches kbd_irq_o on the third rising clk edge after it. A change on kbd_mask_i reaches it on the second rising edge.
- R8: status_flag_o rises on the fourth rising slow_clk edge after status_raw_i goes high. This follows from two synchronizer stages and two consecutive high samples.
- R9: A high pulse on status_raw_i that is caught by only one slow_clk edge never sets status_flag_o.
- R10: status_flag_o falls on the third rising slow_clk edge after status_raw_i goes low. No second low sample is needed.
- R11: A high level on ext_wake_i drives wake_req_o high regardless of the keyboard columns and the configuration bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| slow_clk | input | 1 | Low-frequency sampling clock (about 16 kHz) for the status deglitcher |
| rst_n | input | 1 | Synchronous active-low reset, used in both clock domains |
| kbd_col_i | input | 8 | Raw keyboard column inputs, active high |
| cfg_direct_wake_i | input | 1 | 1: a keypress wakes the system regardless of the mask |
| cfg_six_col_i | input | 1 | 1: only columns 5..0 are merged |
| kbd_mask_i | input | 1 | Keyboard interrupt enable |
| ext_wake_i | input | 1 | External wake pin, active high |
| status_raw_i | input | 1 | Slow external status line, active high |
| kbd_irq_o | output | 1 | Keyboard interrupt request |
| wake_req_o | output | 1 | Wake-up request to the power manager |
| status_flag_o | output | 1 | Deglitched status flag, in the slow_clk domain |

## Verification
The bench drives only the top two columns while six-column mode is on. A design that failed to narrow the merge would raise a spurious interrupt, or wake the system from a pin that had been handed over to GPIO. It also looks for a wake-up when direct wake is off and the mask is clear; a design that ORed the mask into wake without the enable term would wake there. Cycle-exact samples around the synchronizer latency and the deglitcher edges expose an extra or a missing register stage. A single-sample status pulse would wrongly set the flag in a deglitcher that counts only one sample.

// File: rtl/kbw_pkg.sv
// Package: kbw_pkg
// Shared types for the keyboard wake controller.
// Assumes: nothing beyond standard SystemVerilog.
package kbw_pkg;

    // Captured configuration for the column merge.
    typedef struct packed {
        logic six_col;      // merge columns 5..0 only
        logic direct_wake;  // keypress wakes regardless of the mask
        logic kbd_mask;     // keyboard interrupt enabled
    } kbw_cfg_t;

    localparam kbw_cfg_t KBW_CFG_RESET = '{six_col: 1'b0, direct_wake: 1'b0, kbd_mask: 1'b0};

endpackage : kbw_pkg

// File: rtl/kbw_sync.sv
// Module: kbw_sync
// Multi-bit chain of flip-flops that brings asynchronous levels into the
// clock domain of clk. Each bit is synchronized on its own, so a multi-bit
// value may be seen torn for one cycle.
// Assumes: rst_n is synchronous to clk and active low.
module kbw_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw input in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Pass the value down the chain one stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule : kbw_sync

// File: rtl/kbw_col_merge.sv
// Module: kbw_col_merge
// Merges the synchronized keyboard columns into a keypress level. From it,
// the module derives a registered interrupt request (gated by the mask) and
// a registered wake request (gated by mask or direct-wake, plus the external
// wake pin).
// Assumes: all inputs are already synchronous to clk.
module kbw_col_merge
    import kbw_pkg::*;
#(
    parameter int COLS        = 8,
    parameter int NARROW_COLS = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] cols_i,
    input  kbw_cfg_t        cfg_i,
    input  logic            ext_wake_i,
    output logic            irq_o,
    output logic            wake_o
);

    logic [COLS-1:0] col_en;
    logic            key_any;
    logic            irq_q;
    logic            wake_q;

    genvar c;
    generate
        for (c = 0; c < COLS; c++) begin : g_col_en
            if (c < NARROW_COLS) begin : g_always
                assign col_en[c] = 1'b1;
            end else begin : g_wide_only
                assign col_en[c] = ~cfg_i.six_col;
            end
        end
    endgenerate

    assign key_any = |(cols_i & col_en);

    // Register the interrupt and wake requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            irq_q  <= key_any & cfg_i.kbd_mask;
            wake_q <= ext_wake_i | (key_any & (cfg_i.direct_wake | cfg_i.kbd_mask));
        end
    end

    assign irq_o  = irq_q;
    assign wake_o = wake_q;

    // R3
    six_col_upper_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.six_col && cols_i[NARROW_COLS-1:0] == '0) |=> !irq_q);

    // R4
    direct_wake_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.direct_wake && cols_i[0]) |=> wake_q);

    // R5
    no_masked_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.direct_wake && !cfg_i.kbd_mask && !ext_wake_i) |=> !wake_q);

    // R6
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.kbd_mask |=> !irq_q);

    // R11
    ext_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wake_i |=> wake_q);

endmodule : kbw_col_merge

// File: rtl/kbw_deglitch.sv
// Module: kbw_deglitch
// Deglitches a slow status line in the slow sampling clock domain. The line
// is synchronized, then reported only after SAMPLES consecutive high
// samples. A single low sample clears the flag.
// Assumes: rst_n is held low across at least SYNC_STAGES slow_clk edges.
module kbw_deglitch #(
    parameter int SAMPLES     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic slow_clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flag_o
);

    localparam int CNT_W = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SAMPLES - 1);

    logic             smp;
    logic [CNT_W-1:0] run_q;
    logic             flag_q;

    kbw_sync #(
        .WIDTH (1),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (slow_clk),
        .rst_n  (rst_n),
        .async_i(raw_i),
        .sync_o (smp)
    );

    // Count consecutive high samples (saturating) and set the flag.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_q <= 1'b0;
        end else if (!smp) begin
            run_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (run_q != CNT_TOP) run_q <= run_q + 1'b1;
            flag_q <= (run_q == CNT_TOP);
        end
    end

    assign flag_o = flag_q;

    // R10
    low_sample_clears_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
        !smp |=> !flag_q);

    // R8
    rise_needs_high_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(smp));

endmodule : kbw_deglitch

// File: rtl/kbd_wake_ctrl.sv
// Module: kbd_wake_ctrl
// Top of the keyboard wake controller. It captures the configuration,
// synchronizes the columns and the wake pin, merges them into an interrupt
// request and a wake request, and deglitches the slow status line.
// Assumes: rst_n is synchronous to clk and held across two slow_clk edges.
module kbd_wake_ctrl
    import kbw_pkg::*;
#(
    parameter int COLS           = 8,
    parameter int NARROW_COLS    = 6,
    parameter int SYNC_STAGES    = 2,
    parameter int STATUS_SAMPLES = 2
) (
    input  logic            clk,
    input  logic            slow_clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] kbd_col_i,
    input  logic            cfg_direct_wake_i,
    input  logic            cfg_six_col_i,
    input  logic            kbd_mask_i,
    input  logic            ext_wake_i,
    input  logic            status_raw_i,
    output logic            kbd_irq_o,
    output logic            wake_req_o,
    output logic            status_flag_o
);

    localparam int SYNC_W = COLS + 1;

    kbw_cfg_t          cfg_q;
    logic [SYNC_W-1:0] sync_out;
    logic [COLS-1:0]   cols_s;
    logic              ext_s;

    // Capture the configuration and mask bits; they clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= KBW_CFG_RESET;
        else        cfg_q <= '{six_col: cfg_six_col_i,
                               direct_wake: cfg_direct_wake_i,
                               kbd_mask: kbd_mask_i};
    end

    kbw_sync #(
        .WIDTH (SYNC_W),
        .STAGES(SYNC_STAGES)
    ) u_in_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({ext_wake_i, kbd_col_i}),
        .sync_o (sync_out)
    );

    assign cols_s = sync_out[COLS-1:0];
    assign ext_s  = sync_out[COLS];

    kbw_col_merge #(
        .COLS       (COLS),
        .NARROW_COLS(NARROW_COLS)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cols_i    (cols_s),
        .cfg_i     (cfg_q),
        .ext_wake_i(ext_s),
        .irq_o     (kbd_irq_o),
        .wake_o    (wake_req_o)
    );

    kbw_deglitch #(
        .SAMPLES    (STATUS_SAMPLES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_status (
        .slow_clk(slow_clk),
        .rst_n   (rst_n),
        .raw_i   (status_raw_i),
        .flag_o  (status_flag_o)
    );

    // R6
    irq_after_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_irq_o |-> $past(cfg_q.kbd_mask));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!kbd_irq_o && !wake_req_o));

endmodule : kbd_wake_ctrl

// File: tb/kbd_wake_ctrl_tb_top.sv
module kbd_wake_ctrl_tb_top;

    localparam time CLK_PERIOD  = 10ns;
    localparam time SLOW_PERIOD = 160ns;
    localparam int  WATCHDOG    = 200000;

    logic       clk = 1'b0;
    logic       slow_clk = 1'b0;
    logic       rst_n;
    logic [7:0] kbd_col;
    logic       cfg_direct, cfg_six, kbd_mask, ext_wake, status_raw;
    logic       kbd_irq, wake_req, status_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

    kbd_wake_ctrl dut_i (
        .clk              (clk),
        .slow_clk         (slow_clk),
        .rst_n            (rst_n),
        .kbd_col_i        (kbd_col),
        .cfg_direct_wake_i(cfg_direct),
        .cfg_six_col_i    (cfg_six),
        .kbd_mask_i       (kbd_mask),
        .ext_wake_i       (ext_wake),
        .status_raw_i     (status_raw),
        .kbd_irq_o        (kbd_irq),
        .wake_req_o       (wake_req),
        .status_flag_o    (status_flag)
    );

    // {six, direct, mask, ext, cols[7:0], exp_irq, exp_wake}
    localparam logic [13:0] VECS [14] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // idle
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 1'b1, 1'b1},  // R2 bit0, masked-in
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b1},  // R2 bit7 counts
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h80, 1'b0, 1'b0},  // R3 bit7 ignored
        {1'b1, 1'b0, 1'b1, 1'b0, 8'hC0, 1'b0, 1'b0},  // R3 top two ignored
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h20, 1'b1, 1'b1},  // R3 bit5 counts
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h04, 1'b0, 1'b1},  // R4 bypass, R6 no irq
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b0, 1'b0},  // R5 no wake
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h04, 1'b0, 1'b1},  // R11 ext wakes
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},  // R11 ext alone
        {1'b0, 1'b1, 1'b1, 1'b0, 8'h10, 1'b1, 1'b1},  // R6 irq with direct
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h40, 1'b0, 1'b0},  // R3 wake narrowed
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1},  // R4 in six-col mode
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}   // R4 no key, no wake
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        kbd_col = 8'hFF; cfg_direct = 1'b1; cfg_six = 1'b0;
        kbd_mask = 1'b1; ext_wake = 1'b1; status_raw = 1'b1;
        repeat (64) @(negedge clk);
        check("R1 irq in reset", kbd_irq, 1'b0);
        check("R1 wake in reset", wake_req, 1'b0);
        check("R1 status in reset", status_flag, 1'b0);
        kbd_col = 8'h00; cfg_direct = 1'b0; kbd_mask = 1'b0;
        ext_wake = 1'b0; status_raw = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 irq after release", kbd_irq, 1'b0);
        check("R1 wake after release", wake_req, 1'b0);

        // Vector table
        for (int i = 0; i < 14; i++) begin
            {cfg_six, cfg_direct, kbd_mask, ext_wake, kbd_col} = VECS[i][13:2];
            repeat (5) @(negedge clk);
            check($sformatf("R2/R3/R4/R5/R6/R11 vec%0d irq", i), kbd_irq, VECS[i][1]);
            check($sformatf("R2/R3/R4/R5/R6/R11 vec%0d wake", i), wake_req, VECS[i][0]);
        end

        // R7 column latency: three rising edges
        {cfg_six, cfg_direct, kbd_mask, ext_wake, kbd_col} = {4'b0010, 8'h00};
        repeat (5) @(negedge clk);
        kbd_col = 8'h01;
        repeat (2) @(negedge clk);
        check("R7 column not yet at edge 2", kbd_irq, 1'b0);
        @(negedge clk);
        check("R7 column at edge 3", kbd_irq, 1'b1);

        // R7 mask latency: two rising edges
        kbd_mask = 1'b0;
        repeat (5) @(negedge clk);
        kbd_mask = 1'b1;
        @(negedge clk);
        check("R7 mask not yet at edge 1", kbd_irq, 1'b0);
        @(negedge clk);
        check("R7 mask at edge 2", kbd_irq, 1'b1);
        kbd_col = 8'h00; kbd_mask = 1'b0;

        // R8 status rise on fourth slow edge
        @(negedge slow_clk);
        status_raw = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(posedge slow_clk); #20ns;
            if (k == 3) check("R8 flag low at slow edge 3", status_flag, 1'b0);
            if (k == 4) check("R8 flag high at slow edge 4", status_flag, 1'b1);
        end

        // R10 status fall on third slow edge
        @(negedge slow_clk);
        status_raw = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(posedge slow_clk); #20ns;
            if (k == 2) check("R10 flag still high at slow edge 2", status_flag, 1'b1);
            if (k == 3) check("R10 flag low at slow edge 3", status_flag, 1'b0);
        end

        // R9 one-sample pulse rejected
        @(negedge slow_clk);
        status_raw = 1'b1;
        @(negedge slow_clk);
        status_raw = 1'b0;
        begin
            logic seen;
            seen = 1'b0;
            for (int k = 0; k < 6; k++) begin
                @(posedge slow_clk); #20ns;
                seen = seen | status_flag;
            end
            check("R9 single-sample pulse", seen, 1'b0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule : kbd_wake_ctrl_tb_top